// File: doc/BRIEF.md
# Program Counter Sequencer with Conditional Skips

This block owns the program counter of a small single-issue core with a one-deep fetch pipeline. In every cycle the block presents a fetch address. The instruction fetched in one cycle is executed in the next. The block looks at the instruction now in the execute slot, together with a zero flag and a tested bit value supplied by the data path, and it decides the next fetch address. It also keeps a shallow hardware return stack for subroutine calls.

Jumps, calls and returns are all redirecting control transfers, and so is a data-path write into the low byte of the counter. Each of these throws away the instruction that was fetched behind it, and the block marks the following execute slot as a bubble. A conditional skip also throws away the next instruction, but only when the skip is taken. When it is not taken, the skip costs no extra cycle. A return also tells the data path to load the instruction's 8-bit literal into the working register in the same cycle.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst_n` is low at a rising edge, the counter is loaded with 0x1FF. After release, `fetch_addr` reads 0x1FF and `bubble` is low.
- R2: An ordinary instruction moves `fetch_addr` to the next address modulo 512, so 0x1FF is followed by 0x000, and no bubble is raised.
- R3: An instruction with bits [11:9] = 101 loads its bits [8:0] into the counter and raises `bubble` for the next cycle.
- R4: An instruction with bits [11:8] = 1001 pushes the current `fetch_addr` onto the return stack. It loads {0, bits [7:0]}, so bit 8 is always zero, and it raises `bubble`.
- R5: An instruction with bits [11:8] = 1000 pops the return stack into the counter and raises `bubble`. In the same cycle it drives `w_load` high with `w_lit` equal to bits [7:0].
- R6: The return stack holds two entries. A push onto a full stack drops the oldest entry. A pop moves the older entry up and leaves a copy of it behind, so a further pop returns that same address again.
- R7: Bits [11:6] = 001011 or 001111 select a skip-if-zero instruction. It is taken when `zero_flag` is 1: the counter still advances by one and `bubble` is raised. When `zero_flag` is 0 the instruction behaves as an ordinary one. Other opcodes ignore `zero_flag`.
- R8: Bits [11:8] = 0110 select a skip when `bit_val` is 0, and 0111 a skip when `bit_val` is 1. A taken bit-test skip behaves as in R7.
- R9: When `pcl_we` is high and the executing instruction is not a jump, call or return, the counter is loaded with {0, `pcl_data`} and `bubble` is raised. A jump, call or return takes priority over `pcl_we`.
- R10: In a cycle where `bubble` is high, `instr`, `zero_flag`, `bit_val` and `pcl_we` have no effect. The counter advances by one, the stack is unchanged, `w_load` stays low, and `bubble` falls in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| instr | input | 12 | Instruction in the execute slot |
| zero_flag | input | 1 | Zero result of the current increment/decrement |
| bit_val | input | 1 | Value of the bit under test |
| pcl_we | input | 1 | Data path writes the counter's low byte |
| pcl_data | input | 8 | Byte written by the data path |
| fetch_addr | output | 9 | Address being fetched this cycle |
| bubble | output | 1 | Execute slot holds a discarded instruction |
| w_load | output | 1 | Load literal into the working register |
| w_lit | output | 8 | Literal carried by the executing instruction |

## Verification
Some properties are checked on every cycle. For jumps, the new counter value must match the target. After a call, bit 8 must be clear. A taken skip must raise a single bubble, and no bubble may follow another bubble. An ordinary instruction must advance the counter by exactly one, and the top of the stack must equal the address last pushed. Other behaviour shows only in the bench's scenarios: the order of returns after two or three nested calls, the repeated address on a pop from an exhausted stack, the literal seen at the port, and the fact that a call, return or counter write presented during a bubble leaves no trace.

// File: rtl/pcseq_pkg.sv
// Shared types of the program counter sequencer.
// Assumes nothing beyond a 12-bit instruction word.
package pcseq_pkg;
    typedef enum logic [2:0] {
        OP_PLAIN,   // advances by one unless data path writes the counter
        OP_JUMP,    // 9-bit absolute target
        OP_CALL,    // 8-bit target, pushes return address
        OP_RET,     // pops return address, literal to W
        OP_SKIPZ,   // skip when zero flag set
        OP_BTC,     // skip when tested bit clear
        OP_BTS      // skip when tested bit set
    } op_kind_t;
endpackage

// File: rtl/pcseq_decode.sv
// Classifies the executing instruction into the control classes the
// sequencer reacts to, and extracts its targets and literal.
// Assumes PC_W == INSTR_W - 3 and LIT_W == INSTR_W - 4.
module pcseq_decode
    import pcseq_pkg::*;
#(
    parameter int INSTR_W = 12,
    parameter int PC_W    = 9
) (
    input  logic [INSTR_W-1:0] instr,
    output op_kind_t           kind,
    output logic [PC_W-1:0]    jump_tgt,
    output logic [PC_W-1:0]    call_tgt,
    output logic [INSTR_W-5:0] lit
);
    localparam int LIT_W = INSTR_W - 4;

    logic [3:0] top4;
    logic [1:0] mid2;

    assign top4     = instr[INSTR_W-1 -: 4];
    assign mid2     = instr[INSTR_W-5 -: 2];
    assign lit      = instr[LIT_W-1:0];
    assign jump_tgt = instr[PC_W-1:0];
    assign call_tgt = {{(PC_W-LIT_W){1'b0}}, instr[LIT_W-1:0]};

    // Purpose: map opcode bits onto a control class.
    always_comb begin
        kind = OP_PLAIN;
        if (top4[3:1] == 3'b101)                          kind = OP_JUMP;
        else if (top4 == 4'b1001)                         kind = OP_CALL;
        else if (top4 == 4'b1000)                         kind = OP_RET;
        else if (top4 == 4'b0110)                         kind = OP_BTC;
        else if (top4 == 4'b0111)                         kind = OP_BTS;
        else if ((top4 == 4'b0010 || top4 == 4'b0011) && mid2 == 2'b11)
                                                          kind = OP_SKIPZ;
    end
endmodule

// File: rtl/pcseq_stack.sv
// Shift-register return stack. A push moves every entry down one place,
// so the oldest entry is dropped when the stack is full. A pop moves
// every entry up one place and the bottom entry keeps its value.
// Assumes push and pop are never high together and DEPTH >= 2.
module pcseq_stack #(
    parameter int W     = 9,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] push_data,
    output logic [W-1:0] top
);
    logic [W-1:0] ent [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        if (i == 0) begin : g_head
            // Purpose: head entry takes new data on push, next entry on pop.
            always_ff @(posedge clk) begin
                if (!rst_n)    ent[i] <= '0;
                else if (push) ent[i] <= push_data;
                else if (pop)  ent[i] <= ent[i+1];
            end
        end else if (i == DEPTH - 1) begin : g_tail
            // Purpose: tail entry shifts down on push, holds on pop.
            always_ff @(posedge clk) begin
                if (!rst_n)    ent[i] <= '0;
                else if (push) ent[i] <= ent[i-1];
            end
        end else begin : g_mid
            // Purpose: middle entries shift in either direction.
            always_ff @(posedge clk) begin
                if (!rst_n)    ent[i] <= '0;
                else if (push) ent[i] <= ent[i-1];
                else if (pop)  ent[i] <= ent[i+1];
            end
        end
    end

    assign top = ent[0];

    // R6: the address pushed is the one a following pop will return.
    a_r6_push_top: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> top == $past(push_data));
    a_r6_no_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop));
endmodule

// File: rtl/pc_sequencer.sv
// Next-fetch-address logic for a core with a one-deep fetch pipeline.
// fetch_addr is the address fetched this cycle. instr is the word that
// was fetched in the previous cycle. Redirects and taken skips squash
// that fetched word, and bubble flags it while it sits in execute.
// Assumes the data path ignores its execute slot while bubble is high.
module pc_sequencer
    import pcseq_pkg::*;
#(
    parameter int          INSTR_W     = 12,
    parameter int          PC_W        = 9,
    parameter int          STACK_DEPTH = 2,
    parameter logic [8:0]  RESET_PC    = 9'h1FF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] instr,
    input  logic               zero_flag,
    input  logic               bit_val,
    input  logic               pcl_we,
    input  logic [INSTR_W-5:0] pcl_data,
    output logic [PC_W-1:0]    fetch_addr,
    output logic               bubble,
    output logic               w_load,
    output logic [INSTR_W-5:0] w_lit
);
    localparam int LIT_W = INSTR_W - 4;

    op_kind_t         kind;
    logic [PC_W-1:0]  jump_tgt, call_tgt, stk_top;
    logic [PC_W-1:0]  pc_q, pc_d;
    logic             kill_q, kill_d;
    logic             push, pop, take_skip, live;

    pcseq_decode #(.INSTR_W(INSTR_W), .PC_W(PC_W)) u_dec (
        .instr   (instr),
        .kind    (kind),
        .jump_tgt(jump_tgt),
        .call_tgt(call_tgt),
        .lit     (w_lit)
    );

    pcseq_stack #(.W(PC_W), .DEPTH(STACK_DEPTH)) u_stk (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .pop      (pop),
        .push_data(pc_q),
        .top      (stk_top)
    );

    assign live = !kill_q;

    // Purpose: evaluate the skip condition of the executing instruction.
    always_comb begin
        unique case (kind)
            OP_SKIPZ: take_skip = zero_flag;
            OP_BTC:   take_skip = !bit_val;
            OP_BTS:   take_skip = bit_val;
            default:  take_skip = 1'b0;
        endcase
    end

    // Purpose: choose next address, stack action and squash for this cycle.
    always_comb begin
        pc_d   = pc_q + PC_W'(1);
        kill_d = 1'b0;
        push   = 1'b0;
        pop    = 1'b0;
        w_load = 1'b0;
        if (live) begin
            case (kind)
                OP_JUMP: begin
                    pc_d   = jump_tgt;
                    kill_d = 1'b1;
                end
                OP_CALL: begin
                    push   = 1'b1;
                    pc_d   = call_tgt;
                    kill_d = 1'b1;
                end
                OP_RET: begin
                    pop    = 1'b1;
                    pc_d   = stk_top;
                    w_load = 1'b1;
                    kill_d = 1'b1;
                end
                default: begin
                    if (pcl_we) begin
                        pc_d   = {{(PC_W-LIT_W){1'b0}}, pcl_data};
                        kill_d = 1'b1;
                    end else if (take_skip) begin
                        kill_d = 1'b1;
                    end
                end
            endcase
        end
    end

    // Purpose: hold the counter and the squash flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q   <= RESET_PC[PC_W-1:0];
            kill_q <= 1'b0;
        end else begin
            pc_q   <= pc_d;
            kill_q <= kill_d;
        end
    end

    assign fetch_addr = pc_q;
    assign bubble     = kill_q;

    // R2: an ordinary instruction advances by exactly one without a bubble.
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (live && kind == OP_PLAIN && !pcl_we)
        |=> (fetch_addr == $past(fetch_addr) + PC_W'(1)) && !bubble);
    // R3: a jump lands on its full target.
    a_r3_jump: assert property (@(posedge clk) disable iff (!rst_n)
        (live && kind == OP_JUMP)
        |=> (fetch_addr == $past(instr[PC_W-1:0])) && bubble);
    // R4: a call always clears the top counter bit.
    a_r4_call_hibit: assert property (@(posedge clk) disable iff (!rst_n)
        (live && kind == OP_CALL) |=> !fetch_addr[PC_W-1] && bubble);
    // R5: literal strobe never comes from a squashed slot.
    a_r5_wload_live: assert property (@(posedge clk) disable iff (!rst_n)
        w_load |-> !bubble);
    // R7: a taken skip costs one bubble and skips exactly one address.
    a_r7_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (live && take_skip && !pcl_we)
        |=> bubble && (fetch_addr == $past(fetch_addr) + PC_W'(1)));
    // R10: a bubble never lasts two cycles.
    a_r10_single: assert property (@(posedge clk) disable iff (!rst_n)
        bubble |=> !bubble);
endmodule

// File: tb/pc_sequencer_test.sv
module pc_sequencer_test;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] instr = 12'h000;
    logic        zero_flag = 1'b0;
    logic        bit_val = 1'b0;
    logic        pcl_we = 1'b0;
    logic [7:0]  pcl_data = 8'h00;
    logic [8:0]  fetch_addr;
    logic        bubble, w_load;
    logic [7:0]  w_lit;

    int n_cmp = 0;
    int n_bad = 0;

    // reference state
    logic [8:0] m_pc;
    logic       m_kill;
    logic [8:0] m_s0, m_s1;

    always #(PERIOD/2) clk = ~clk;

    pc_sequencer uut (
        .clk(clk), .rst_n(rst_n), .instr(instr), .zero_flag(zero_flag),
        .bit_val(bit_val), .pcl_we(pcl_we), .pcl_data(pcl_data),
        .fetch_addr(fetch_addr), .bubble(bubble), .w_load(w_load), .w_lit(w_lit)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // One execute cycle: drive at negedge, check strobe, advance model, check state.
    task automatic step(input logic [11:0] i, input logic z, input logic b,
                        input logic we, input logic [7:0] d, input string tag_in);
        string tag;
        logic is_jmp, is_call, is_ret, is_sz, is_btc, is_bts, skip, e_wl;
        logic [8:0] npc;
        logic nkill;
        instr = i; zero_flag = z; bit_val = b; pcl_we = we; pcl_data = d;
        is_jmp  = (i[11:9] == 3'b101);
        is_call = (i[11:8] == 4'b1001);
        is_ret  = (i[11:8] == 4'b1000);
        is_btc  = (i[11:8] == 4'b0110);
        is_bts  = (i[11:8] == 4'b0111);
        is_sz   = (i[11:6] == 6'b001011) || (i[11:6] == 6'b001111);
        skip    = (is_sz && z) || (is_btc && !b) || (is_bts && b);
        npc = m_pc + 9'd1; nkill = 1'b0; e_wl = 1'b0;
        if (m_kill)       tag = "R10";
        else if (is_jmp)  tag = "R3";
        else if (is_call) tag = "R4";
        else if (is_ret)  tag = "R5";
        else if (we)      tag = "R9";
        else if (is_sz)   tag = "R7";
        else if (is_btc || is_bts) tag = "R8";
        else              tag = "R2";
        if (tag_in != "") tag = tag_in;
        if (!m_kill) begin
            if (is_jmp) begin
                npc = i[8:0]; nkill = 1'b1;
            end else if (is_call) begin
                m_s1 = m_s0; m_s0 = m_pc; npc = {1'b0, i[7:0]}; nkill = 1'b1;
            end else if (is_ret) begin
                npc = m_s0; m_s0 = m_s1; nkill = 1'b1; e_wl = 1'b1;
            end else if (we) begin
                npc = {1'b0, d}; nkill = 1'b1;
            end else if (skip) begin
                nkill = 1'b1;
            end
        end
        #1;
        chk({tag, " w_load"}, int'(w_load), int'(e_wl));
        if (e_wl) chk({tag, " w_lit"}, int'(w_lit), int'(i[7:0]));
        @(posedge clk);
        m_pc = npc; m_kill = nkill;
        @(negedge clk);
        chk({tag, " fetch_addr"}, int'(fetch_addr), int'(m_pc));
        chk({tag, " bubble"}, int'(bubble), int'(m_kill));
    endtask

    task automatic nop(); step(12'h000, 1'b0, 1'b0, 1'b0, 8'h00, ""); endtask

    initial begin
        #(PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        m_pc = 9'h1FF; m_kill = 1'b0; m_s0 = '0; m_s1 = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 fetch_addr", int'(fetch_addr), 'h1FF);
        chk("R1 bubble", int'(bubble), 0);

        // R2: sequential run wraps past the top address
        repeat (4) nop();

        // R3: every jump target
        for (int t = 0; t < 512; t++) begin
            step({3'b101, 9'(t)}, 1'b0, 1'b0, 1'b0, 8'h00, "");
            nop();
        end

        // R4/R5: call from the upper half, then return with a literal
        for (int k = 0; k < 256; k++) begin
            step({3'b101, 1'b1, 8'(k)}, 1'b0, 1'b0, 1'b0, 8'h00, "");
            nop();
            step({4'b1001, 8'(k)}, 1'b0, 1'b0, 1'b0, 8'h00, "");
            nop();
            step({4'b1000, 8'(255 - k)}, 1'b0, 1'b0, 1'b0, 8'h00, "");
            nop();
        end

        // R6: nesting two and three deep, then pops past the bottom
        for (int depth = 2; depth <= 3; depth++) begin
            step(12'hA50, 1'b0, 1'b0, 1'b0, 8'h00, "R6");
            nop();
            for (int c = 0; c < depth; c++) begin
                step({4'b1001, 8'(8'h10 * (c + 1))}, 1'b0, 1'b0, 1'b0, 8'h00, "R6");
                nop();
            end
            for (int r = 0; r < 4; r++) begin
                step({4'b1000, 8'(r)}, 1'b0, 1'b0, 1'b0, 8'h00, "R6");
                nop();
            end
        end

        // R7/R8: every operand field of each skip class, both conditions
        for (int cls = 0; cls < 4; cls++) begin
            for (int lo = 0; lo < 64; lo++) begin
                for (int c = 0; c < 2; c++) begin
                    logic [5:0] hi;
                    hi = (cls == 0) ? 6'b001011 : (cls == 1) ? 6'b001111 :
                         (cls == 2) ? {4'b0110, 2'(lo >> 4)} : {4'b0111, 2'(lo >> 4)};
                    step({hi, 6'(lo)}, c[0], c[0], 1'b0, 8'h00, "");
                    nop();
                end
            end
        end
        // R7: neighbouring opcodes with zero flag set must not skip
        for (int lo = 0; lo < 64; lo++) begin
            step({6'b000011, 6'(lo)}, 1'b1, 1'b1, 1'b0, 8'h00, "R7");
            step({6'b001010, 6'(lo)}, 1'b1, 1'b1, 1'b0, 8'h00, "R7");
        end

        // R9: data-path write of the low byte, with and without conflict
        for (int d = 0; d < 256; d++) begin
            step(12'hB80, 1'b0, 1'b0, 1'b0, 8'h00, "");
            nop();
            step(12'h000, 1'b0, 1'b0, 1'b1, 8'(d), "R9");
            nop();
        end
        step({3'b101, 9'h123}, 1'b0, 1'b0, 1'b1, 8'h44, "R9");
        nop();

        // R10: control words, skips and writes in the squashed slot are ignored
        for (int k = 0; k < 32; k++) begin
            step(12'hA00 | 12'(k), 1'b0, 1'b0, 1'b0, 8'h00, "");
            step({4'b1001, 8'(k)}, 1'b1, 1'b1, 1'b1, 8'(k), "R10");
            step(12'h2C0, 1'b1, 1'b1, 1'b0, 8'h00, "");
            step({4'b1000, 8'(k)}, 1'b1, 1'b1, 1'b1, 8'hEE, "R10");
            step(12'h700, 1'b1, 1'b1, 1'b0, 8'h00, "");
            step({3'b101, 9'h000}, 1'b1, 1'b1, 1'b1, 8'h00, "R10");
            step({4'b1000, 8'h5A}, 1'b0, 1'b0, 1'b0, 8'h00, "R10");
            nop();
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule